// File: doc/BRIEF.md
# Recursive 8x8 Approximate Multiplier

This block multiplies two unsigned 8-bit operands and returns a 16-bit product without any clock. Each operand is cut into a high nibble and a low nibble. Four 4x4 sub-multipliers then work in parallel on the nibble pairs: low-by-low, low-by-high, high-by-low and high-by-high. An exact 16-bit merge adds their results, each shifted to its weight. The high-by-high result is shifted left by 8, the two cross terms by 4, and the low-by-low result is not shifted. Every approximation therefore comes from the sub-multipliers, and none from the merge.

A compile-time parameter picks the kind of 4x4 sub-multiplier used at each position. The exact kind multiplies the nibbles exactly. The chain kind compresses nibble columns 3 and 4, where the column number is i+j for a[i]&b[j]. It uses an approximate 4:2 compressor with carry in and carry out: p=(x1^x2)|(x3^x4), sum=p^cin, carry=p&cin, cout=x1x2|x3x4. Column 3 takes cin=0. Column 4 takes x4=0 and the carry out of column 3. The flat kind compresses only column 3, with sum=(x1^x2)|(x3^x4) and carry=x1x2|x3x4. In column 3, x1..x4 are a0b3, a1b2, a2b1 and a3b0. In column 4, x1..x3 are a1b3, a2b2 and a3b1. All other partial-product bits are added exactly.

There are four configurations. The exact configuration uses exact sub-multipliers everywhere and serves as the golden reference. All-chain uses chain sub-multipliers at all four positions. Low-chain uses a chain sub-multiplier only for low-by-low and exact ones elsewhere. All-flat uses flat sub-multipliers at all four positions. The block suits error-tolerant datapaths, where a smaller multiplier is worth a bounded shortfall.

Top module: `approx_mul8`

## Requirements
- R1: In the exact configuration, prod_o equals opa_i*opb_i for every one of the 65536 operand pairs.
- R2: In the low-chain configuration, the shortfall opa_i*opb_i - prod_o lies between 0 and 24 for every pair, because only the least significant sub-product is approximate and the merge is exact.
- R3: In every configuration, a zero in either operand gives a product of 0.
- R4: In every configuration, an operand equal to 1 gives the other operand as the product.
- R5: In every approximate configuration, prod_o never exceeds the exact product.
- R6: With both operands at 255, all-chain and all-flat give 60401, and low-chain gives 65009.
- R7: Over all pairs, the mean error distance of all-chain is greater than 0 and at most 800.
- R8: Over all pairs, the mean error distance of all-flat is greater than 0 and at most 350.
- R9: Over all pairs, the mean error distance of low-chain is greater than 0 and at most 3, and the mean error distances are ordered low-chain < all-flat < all-chain.
- R10: The operands 10 and 10 give 84 in the two configurations that use chain sub-multipliers and 100 in all-flat. The operands 5 and 10 give 42 in all three approximate configurations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 8 | Unsigned multiplicand |
| opb_i | input | 8 | Unsigned multiplier |
| prod_o | output | 16 | Product, exact or approximate depending on the configuration |

## Verification
All four configurations are built side by side and receive the same operands, which walk through the whole 65536-pair space. The exact instance has to match the true product everywhere. The sweep's zero and unit operands isolate the cases where no compressor column can hold two set bits, so those inputs show whether an approximate kind is leaking error where it should not. Directed pairs then target particular compressor columns. 10x10 sets column 4 bits, which only the chain kind mishandles. 5x10 makes a cross pair in column 3, which both approximate kinds mishandle. All-ones drives every column full. The accumulated error distances rank the three approximate configurations against each other.

// File: rtl/amul_pkg.sv
package amul_pkg;

  localparam int OP_W   = 8;
  localparam int HALF_W = OP_W / 2;
  localparam int PROD_W = 2 * OP_W;
  localparam int SUB_W  = 2 * HALF_W;
  localparam int NPOS   = 4;

  typedef enum logic [1:0] {
    CFG_EXACT     = 2'd0,
    CFG_ALL_CHAIN = 2'd1,
    CFG_LOW_CHAIN = 2'd2,
    CFG_ALL_FLAT  = 2'd3
  } cfg_e;

  typedef enum logic [1:0] {
    K_EXACT = 2'd0,
    K_CHAIN = 2'd1,
    K_FLAT  = 2'd2
  } kind_e;

  // position 0 = low x low, 1 = low(a) x high(b), 2 = high(a) x low(b), 3 = high x high
  function automatic kind_e kind_at(cfg_e cfg, int pos);
    case (cfg)
      CFG_ALL_CHAIN: return K_CHAIN;
      CFG_ALL_FLAT:  return K_FLAT;
      CFG_LOW_CHAIN: return (pos == 0) ? K_CHAIN : K_EXACT;
      default:       return K_EXACT;
    endcase
  endfunction

  function automatic int pos_shift(int pos);
    return HALF_W * (((pos >> 1) & 1) + (pos & 1));
  endfunction

endpackage

// File: rtl/cmp42_chain.sv
module cmp42_chain (
  input  logic [3:0] x_i,
  input  logic       cin_i,
  output logic       sum_o,
  output logic       carry_o,
  output logic       cout_o
);

  logic pair_odd;

  always_comb begin
    pair_odd = (x_i[0] ^ x_i[1]) | (x_i[2] ^ x_i[3]);
    sum_o    = pair_odd ^ cin_i;
    carry_o  = pair_odd & cin_i;
    cout_o   = (x_i[0] & x_i[1]) | (x_i[2] & x_i[3]);
  end

endmodule

// File: rtl/cmp42_flat.sv
module cmp42_flat (
  input  logic [3:0] x_i,
  output logic       sum_o,
  output logic       carry_o
);

  always_comb begin
    sum_o   = (x_i[0] ^ x_i[1]) | (x_i[2] ^ x_i[3]);
    carry_o = (x_i[0] & x_i[1]) | (x_i[2] & x_i[3]);
  end

endmodule

// File: rtl/nib_mul.sv
module nib_mul
  import amul_pkg::*;
#(
  parameter kind_e KIND = K_EXACT
) (
  input  logic [HALF_W-1:0] a_i,
  input  logic [HALF_W-1:0] b_i,
  output logic [SUB_W-1:0]  p_o
);

  localparam int  COL_A = 3;
  localparam int  COL_B = 4;
  localparam bit  SKIP_B = (KIND == K_CHAIN);

  generate
    if (KIND == K_EXACT) begin : g_exact
      assign p_o = SUB_W'(a_i) * SUB_W'(b_i);
    end else begin : g_approx
      logic [HALF_W-1:0] pp [HALF_W];
      logic [SUB_W-1:0]  rest;
      logic [SUB_W-1:0]  comp;

      always_comb begin
        for (int i = 0; i < HALF_W; i++) begin
          for (int j = 0; j < HALF_W; j++) begin
            pp[i][j] = a_i[i] & b_i[j];
          end
        end
      end

      // exact sum of every partial-product bit outside the compressed columns
      always_comb begin
        rest = '0;
        for (int i = 0; i < HALF_W; i++) begin
          for (int j = 0; j < HALF_W; j++) begin
            if (!((i + j) == COL_A || (SKIP_B && (i + j) == COL_B))) begin
              rest = rest + (SUB_W'(pp[i][j]) << (i + j));
            end
          end
        end
      end

      if (KIND == K_CHAIN) begin : g_chain
        logic s3, c3, co3, s4, c4, co4;

        cmp42_chain u_col3 (
          .x_i    ({pp[3][0], pp[2][1], pp[1][2], pp[0][3]}),
          .cin_i  (1'b0),
          .sum_o  (s3),
          .carry_o(c3),
          .cout_o (co3)
        );

        cmp42_chain u_col4 (
          .x_i    ({1'b0, pp[3][1], pp[2][2], pp[1][3]}),
          .cin_i  (co3),
          .sum_o  (s4),
          .carry_o(c4),
          .cout_o (co4)
        );

        always_comb begin
          comp = (SUB_W'(s3) << COL_A) + (SUB_W'(c3) << COL_B)
               + (SUB_W'(s4) << COL_B) + (SUB_W'(c4) << (COL_B + 1))
               + (SUB_W'(co4) << (COL_B + 1));
        end
      end else begin : g_flat
        logic s3, c3;

        cmp42_flat u_col3 (
          .x_i    ({pp[3][0], pp[2][1], pp[1][2], pp[0][3]}),
          .sum_o  (s3),
          .carry_o(c3)
        );

        always_comb begin
          comp = (SUB_W'(s3) << COL_A) + (SUB_W'(c3) << COL_B);
        end
      end

      assign p_o = rest + comp;
    end
  endgenerate

endmodule

// File: rtl/prod_merge.sv
module prod_merge
  import amul_pkg::*;
(
  input  logic [SUB_W-1:0]  sub_i [NPOS],
  output logic [PROD_W-1:0] prod_o
);

  always_comb begin
    prod_o = '0;
    for (int p = 0; p < NPOS; p++) begin
      prod_o = prod_o + (PROD_W'(sub_i[p]) << pos_shift(p));
    end
  end

endmodule

// File: rtl/approx_mul8.sv
module approx_mul8
  import amul_pkg::*;
#(
  parameter cfg_e CFG = CFG_EXACT
) (
  input  logic [OP_W-1:0]   opa_i,
  input  logic [OP_W-1:0]   opb_i,
  output logic [PROD_W-1:0] prod_o
);

  logic [HALF_W-1:0] a_half [2];
  logic [HALF_W-1:0] b_half [2];
  logic [SUB_W-1:0]  sub    [NPOS];

  assign a_half[0] = opa_i[HALF_W-1:0];
  assign a_half[1] = opa_i[OP_W-1:HALF_W];
  assign b_half[0] = opb_i[HALF_W-1:0];
  assign b_half[1] = opb_i[OP_W-1:HALF_W];

  generate
    for (genvar p = 0; p < NPOS; p++) begin : g_pos
      nib_mul #(
        .KIND(kind_at(CFG, p))
      ) u_nib (
        .a_i(a_half[(p >> 1) & 1]),
        .b_i(b_half[p & 1]),
        .p_o(sub[p])
      );
    end
  endgenerate

  prod_merge u_merge (
    .sub_i (sub),
    .prod_o(prod_o)
  );

endmodule

// File: rtl/approx_mul8_chk.sv
module approx_mul8_chk
  import amul_pkg::*;
#(
  parameter cfg_e CFG = CFG_EXACT
) (
  input logic [OP_W-1:0]   opa_i,
  input logic [OP_W-1:0]   opb_i,
  input logic [PROD_W-1:0] prod_o
);

  logic [PROD_W-1:0] golden;
  logic [PROD_W-1:0] gap;

  always_comb begin
    golden = PROD_W'(opa_i) * PROD_W'(opb_i);
    gap    = golden - prod_o;

    if (CFG == CFG_EXACT) begin
      assert_exact_R1: assert (prod_o == golden);
    end else begin
      assert_no_overshoot_R5: assert (prod_o <= golden);
    end
    if (CFG == CFG_LOW_CHAIN) begin
      assert_low_gap_R2: assert (prod_o > golden || gap <= PROD_W'(24));
    end
    if (opa_i == '0 || opb_i == '0) begin
      assert_zero_R3: assert (prod_o == '0);
    end
    if (opb_i == OP_W'(1)) begin
      assert_unit_b_R4: assert (prod_o == PROD_W'(opa_i));
    end
    if (opa_i == OP_W'(1)) begin
      assert_unit_a_R4: assert (prod_o == PROD_W'(opb_i));
    end
  end

endmodule

bind approx_mul8 approx_mul8_chk #(.CFG(CFG)) u_chk (
  .opa_i (opa_i),
  .opb_i (opb_i),
  .prod_o(prod_o)
);

// File: tb/sim_approx_mul8.sv
module sim_approx_mul8;
  import amul_pkg::*;

  logic        clk;
  logic        rst_n;
  logic [7:0]  opa, opb;
  logic [15:0] p_ex, p_ac, p_lc, p_af;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  longint sum_ac = 0, sum_lc = 0, sum_af = 0;
  int     max_lc = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  approx_mul8 #(.CFG(CFG_EXACT))     u0 (.opa_i(opa), .opb_i(opb), .prod_o(p_ex));
  approx_mul8 #(.CFG(CFG_ALL_CHAIN)) u1 (.opa_i(opa), .opb_i(opb), .prod_o(p_ac));
  approx_mul8 #(.CFG(CFG_LOW_CHAIN)) u2 (.opa_i(opa), .opb_i(opb), .prod_o(p_lc));
  approx_mul8 #(.CFG(CFG_ALL_FLAT))  u3 (.opa_i(opa), .opb_i(opb), .prod_o(p_af));

  task automatic chk_eq(input string rq, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic chk_le(input string rq, input longint act, input longint lim);
    n_chk++;
    if (act > lim) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected<=%0d", rq, act, lim);
    end
  endtask

  task automatic chk_gt(input string rq, input longint act, input longint lim);
    n_chk++;
    if (act <= lim) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected>%0d", rq, act, lim);
    end
  endtask

  task automatic apply(input int a, input int b);
    @(posedge clk);
    #1;
    opa = 8'(a);
    opb = 8'(b);
    @(negedge clk);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    int ref_p;
    rst_n = 1'b0;
    opa   = '0;
    opb   = '0;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 idle state with zero operands
    chk_eq("R3 idle exact", p_ex, 0);
    chk_eq("R3 idle all-chain", p_ac, 0);
    chk_eq("R3 idle low-chain", p_lc, 0);
    chk_eq("R3 idle all-flat", p_af, 0);

    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        apply(a, b);
        ref_p = a * b;
        chk_eq("R1 exact sweep", p_ex, ref_p);
        chk_le("R5 all-chain", p_ac, ref_p);
        chk_le("R5 low-chain", p_lc, ref_p);
        chk_le("R5 all-flat", p_af, ref_p);
        if (ref_p - int'(p_lc) > max_lc) max_lc = ref_p - int'(p_lc);
        sum_ac += (ref_p > int'(p_ac)) ? ref_p - int'(p_ac) : int'(p_ac) - ref_p;
        sum_lc += (ref_p > int'(p_lc)) ? ref_p - int'(p_lc) : int'(p_lc) - ref_p;
        sum_af += (ref_p > int'(p_af)) ? ref_p - int'(p_af) : int'(p_af) - ref_p;
        if (a == 0 || b == 0) begin
          chk_eq("R3 zero all-chain", p_ac, 0);
          chk_eq("R3 zero low-chain", p_lc, 0);
          chk_eq("R3 zero all-flat", p_af, 0);
        end
        if (b == 1 || a == 1) begin
          chk_eq("R4 unit all-chain", p_ac, ref_p);
          chk_eq("R4 unit low-chain", p_lc, ref_p);
          chk_eq("R4 unit all-flat", p_af, ref_p);
        end
      end
    end

    chk_le("R2 low-chain max shortfall", max_lc, 24);
    // mean error distance bounds, scaled by the 65536 pairs
    chk_gt("R7 all-chain MED above zero", sum_ac, 0);
    chk_le("R7 all-chain MED bound", sum_ac, 800 * 65536);
    chk_gt("R8 all-flat MED above zero", sum_af, 0);
    chk_le("R8 all-flat MED bound", sum_af, 350 * 65536);
    chk_gt("R9 low-chain MED above zero", sum_lc, 0);
    chk_le("R9 low-chain MED bound", sum_lc, 3 * 65536);
    chk_gt("R9 order all-flat over low-chain", sum_af, sum_lc);
    chk_gt("R9 order all-chain over all-flat", sum_ac, sum_af);

    apply(255, 255);
    chk_eq("R6 all-ones exact", p_ex, 65025);
    chk_eq("R6 all-ones all-chain", p_ac, 60401);
    chk_eq("R6 all-ones low-chain", p_lc, 65009);
    chk_eq("R6 all-ones all-flat", p_af, 60401);

    apply(10, 10);
    chk_eq("R10 10x10 all-chain", p_ac, 84);
    chk_eq("R10 10x10 low-chain", p_lc, 84);
    chk_eq("R10 10x10 all-flat", p_af, 100);

    apply(5, 10);
    chk_eq("R10 5x10 all-chain", p_ac, 42);
    chk_eq("R10 5x10 low-chain", p_lc, 42);
    chk_eq("R10 5x10 all-flat", p_af, 42);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

endmodule